// File: doc/BRIEF.md
# Hidden Configuration Window for a Disk Task-File Port

This block sits between a host bus and the eight task-file byte/word ports of a disk interface. Most of the time every host access passes straight through to the drive side. A hidden bank of configuration registers shares the same eight offsets. The bank can be reached only after a fixed unlock sequence on the bus. Once the window is open, byte accesses land in the configuration registers and are not forwarded. A second magic write closes the window again.

The configuration space holds a read-timing byte (index 0), a write-timing byte (index 1), a control byte (index 3), a read-only strap byte (index 5) and a misc byte (index 6). The two timing bytes exist in two banks, A and B. Bank B can be reached only after it has been enabled by a special write made while the window is closed. After that, bit 0 of the misc byte picks which bank indices 0 and 1 address. Every host read gets exactly one response, one clock later, carrying either drive data or configuration data.

Top module: `cfg_window_gate`

## Requirements
- R1: After synchronous reset the window is closed (`cfg_open` = 0), `resp_valid` is 0, and once the window is opened the control byte (index 3) and the misc byte (index 6) read 0x00.
- R2: Two word reads (`acc_word` = 1) at offset 1, then a byte write of 0x03 at offset 2, each accepted in turn, set `cfg_open` to 1 from the clock edge that accepts the write.
- R3: While the window is closed, any accepted access that does not continue the unlock sequence returns it to the start, so the key write does not open the window. A wrong data byte, a byte read instead of a word read, or a different offset all count as breaking it.
- R4: While the window is closed, every access is forwarded in the same cycle on `dev_*`, with offset, width, direction and data unchanged. A read's response carries the value of `dev_rdata` sampled in the accepting cycle. This includes the unlock accesses.
- R5: While the window is open, a byte access at offset N reaches configuration index N and is not forwarded (`dev_valid` = 0). Word accesses are still forwarded to the drive.
- R6: While the window is open, a byte write of 0x83 at offset 2 closes it (`cfg_open` = 0 after that edge). The write is not forwarded, and the register contents are kept.
- R7: The strap byte (index 5) always reads 0x00, and writes to it have no effect.
- R8: The control byte (index 3) is read/write and returns the last value written through the window.
- R9: Bank B stays unreachable until a byte write of 0xC0 at offset 3 is made while the window is closed. Until then, indices 0 and 1 address bank A whatever the misc byte holds.
- R10: Once bank B is enabled, misc bit 0 selects bank A (0) or bank B (1) for indices 0 and 1. The two banks hold independent values.
- R11: Each accepted read gives `resp_valid` = 1 in the next cycle only, and writes give no response. A configuration read is zero-extended to 16 bits, and indices 2, 4 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access strobe, one access per cycle |
| acc_off | input | 3 | Port offset 0..7 |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| resp_valid | output | 1 | Read response strobe, one cycle after the read |
| resp_data | output | 16 | Read response data |
| cfg_open | output | 1 | Configuration window open |
| dev_valid | output | 1 | Forwarded access strobe to the drive side |
| dev_off | output | 3 | Forwarded offset |
| dev_word | output | 1 | Forwarded width flag |
| dev_wr | output | 1 | Forwarded direction |
| dev_wdata | output | 16 | Forwarded write data |
| dev_rdata | input | 16 | Drive-side read data, valid in the access cycle |

## Verification
Forwarding on `dev_*` is combinational, so it is checked in the accepting cycle, before the clock edge. Read responses and the window state both change at the edge that accepts an access. The monitor therefore samples shortly after each rising edge. At that point it expects `resp_valid` exactly when the previous cycle carried a read, and it pops the expected value queued by the driver. `cfg_open` is checked on the falling edge after the last access of a sequence has been accepted. Bank, strap and unimplemented-index behaviour is observed through read-backs in the window.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_ONE  = 2'd1,
    UL_TWO  = 2'd2,
    UL_OPEN = 2'd3
  } unlock_state_t;

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_window_pkg::*;
#(
  parameter int OFF_W     = 3,
  parameter int CW        = 8,
  parameter int PROBE_OFF = 1,
  parameter int KEY_OFF   = 2,
  parameter logic [7:0] KEY_OPEN  = 8'h03,
  parameter logic [7:0] KEY_CLOSE = 8'h83
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [OFF_W-1:0] off,
  input  logic             word,
  input  logic             wr,
  input  logic [CW-1:0]    wbyte,
  output logic             open
);

  localparam logic [OFF_W-1:0] PROBE_A = OFF_W'(PROBE_OFF);
  localparam logic [OFF_W-1:0] KEY_A   = OFF_W'(KEY_OFF);

  unlock_state_t state_q, state_d;

  logic probe_hit, open_hit, close_hit;

  assign probe_hit = valid && word && !wr && (off == PROBE_A);
  assign open_hit  = valid && !word && wr && (off == KEY_A) && (wbyte == CW'(KEY_OPEN));
  assign close_hit = valid && !word && wr && (off == KEY_A) && (wbyte == CW'(KEY_CLOSE));

  always_comb begin
    state_d = state_q;
    if (valid) begin
      unique case (state_q)
        UL_IDLE: state_d = probe_hit ? UL_ONE  : UL_IDLE;
        UL_ONE:  state_d = probe_hit ? UL_TWO  : UL_IDLE;
        UL_TWO:  state_d = open_hit  ? UL_OPEN : UL_IDLE;
        UL_OPEN: state_d = close_hit ? UL_IDLE : UL_OPEN;
        default: state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= UL_IDLE;
    else     state_q <= state_d;
  end

  assign open = (state_q == UL_OPEN);

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == UL_TWO && open_hit) |=> open);

  // R6
  close_key_chk: assert property (@(posedge clk) disable iff (rst)
    (open && close_hit) |=> !open);

  // R3
  broken_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !open && !probe_hit && !(state_q == UL_TWO && open_hit)) |=> (state_q == UL_IDLE));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int OFF_W     = 3,
  parameter int CW        = 8,
  parameter int BANK_CNT  = 2,
  parameter int RT_IDX    = 0,
  parameter int WT_IDX    = 1,
  parameter int CTRL_IDX  = 3,
  parameter int STRAP_IDX = 5,
  parameter int MISC_IDX  = 6,
  parameter logic [7:0] STRAP_VAL = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [OFF_W-1:0] idx,
  input  logic [CW-1:0]    wdata,
  input  logic             bank_en,
  output logic [CW-1:0]    rdata
);

  localparam int BSEL_W = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1;
  localparam int TADR_W = BSEL_W + 1;
  localparam int TDEPTH = 2 * BANK_CNT;

  logic [CW-1:0] tmg_mem [TDEPTH];
  logic [CW-1:0] ctrl_q, misc_q;
  logic [BSEL_W-1:0] bank_sel;
  logic [TADR_W-1:0] tadr;
  logic is_tmg;

  generate
    if (BANK_CNT > 1) begin : g_multi_bank
      assign bank_sel = bank_en ? misc_q[BSEL_W-1:0] : '0;
    end else begin : g_single_bank
      logic unused_bank;
      assign unused_bank = bank_en;
      assign bank_sel = '0;
    end
  endgenerate

  assign is_tmg = (idx == OFF_W'(RT_IDX)) || (idx == OFF_W'(WT_IDX));
  assign tadr   = {bank_sel, (idx == OFF_W'(WT_IDX))};

  // timing bytes: plain memory, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (we && is_tmg) tmg_mem[tadr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else if (we) begin
      if (idx == OFF_W'(CTRL_IDX)) ctrl_q <= wdata;
      if (idx == OFF_W'(MISC_IDX)) misc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      if (is_tmg)                         rdata <= tmg_mem[tadr];
      else if (idx == OFF_W'(CTRL_IDX))   rdata <= ctrl_q;
      else if (idx == OFF_W'(MISC_IDX))   rdata <= misc_q;
      else if (idx == OFF_W'(STRAP_IDX))  rdata <= CW'(STRAP_VAL);
      else                                rdata <= '0;
    end
  end

  // R7
  strap_const_chk: assert property (@(posedge clk) disable iff (rst)
    (re && idx == OFF_W'(STRAP_IDX)) |=> (rdata == CW'(STRAP_VAL)));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && idx == OFF_W'(CTRL_IDX)) |=> $stable(ctrl_q));

endmodule

// File: rtl/cfg_window_gate.sv
module cfg_window_gate #(
  parameter int OFF_W     = 3,
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int BANK_CNT  = 2,
  parameter int CTRL_IDX  = 3,
  parameter logic [7:0] BANK_KEY = 8'hC0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [OFF_W-1:0] acc_off,
  input  logic             acc_word,
  input  logic             acc_wr,
  input  logic [DW-1:0]    acc_wdata,
  output logic             resp_valid,
  output logic [DW-1:0]    resp_data,
  output logic             cfg_open,
  output logic             dev_valid,
  output logic [OFF_W-1:0] dev_off,
  output logic             dev_word,
  output logic             dev_wr,
  output logic [DW-1:0]    dev_wdata,
  input  logic [DW-1:0]    dev_rdata
);

  logic          to_cfg;
  logic          bank_en_q;
  logic          src_cfg_q;
  logic [DW-1:0] dev_q;
  logic [CW-1:0] cfg_rdata;

  cfg_unlock_fsm #(
    .OFF_W (OFF_W),
    .CW    (CW)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .valid (acc_valid),
    .off   (acc_off),
    .word  (acc_word),
    .wr    (acc_wr),
    .wbyte (acc_wdata[CW-1:0]),
    .open  (cfg_open)
  );

  assign to_cfg = cfg_open && acc_valid && !acc_word;

  cfg_regfile #(
    .OFF_W    (OFF_W),
    .CW       (CW),
    .BANK_CNT (BANK_CNT),
    .CTRL_IDX (CTRL_IDX)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (to_cfg && acc_wr),
    .re      (to_cfg && !acc_wr),
    .idx     (acc_off),
    .wdata   (acc_wdata[CW-1:0]),
    .bank_en (bank_en_q),
    .rdata   (cfg_rdata)
  );

  assign dev_valid = acc_valid && !to_cfg;
  assign dev_off   = acc_off;
  assign dev_word  = acc_word;
  assign dev_wr    = acc_wr;
  assign dev_wdata = acc_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_q <= 1'b0;
    end else if (acc_valid && !cfg_open && !acc_word && acc_wr &&
                 acc_off == OFF_W'(CTRL_IDX) && acc_wdata[CW-1:0] == CW'(BANK_KEY)) begin
      bank_en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      src_cfg_q  <= 1'b0;
      dev_q      <= '0;
    end else begin
      resp_valid <= acc_valid && !acc_wr;
      src_cfg_q  <= to_cfg;
      dev_q      <= dev_rdata;
    end
  end

  assign resp_data = src_cfg_q ? {{(DW-CW){1'b0}}, cfg_rdata} : dev_q;

  // R11
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr) |=> resp_valid);

  // R11
  no_write_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_wr) |=> !resp_valid);

  // R5
  open_byte_local_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && acc_valid && !acc_word) |-> !dev_valid);

  // R4
  closed_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && acc_valid) |-> (dev_valid && dev_off == acc_off && dev_wdata == acc_wdata));

  // R9
  bank_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bank_en_q |=> bank_en_q);

endmodule

// File: tb/test_cfg_window_gate.sv
module test_cfg_window_gate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_off = '0;
  logic        acc_word = 1'b0;
  logic        acc_wr = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic        resp_valid, cfg_open, dev_valid, dev_word, dev_wr;
  logic [15:0] resp_data, dev_wdata, dev_rdata;
  logic [2:0]  dev_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_q[$];
  bit mon_exp;

  always #10 clk = ~clk;

  // drive-side model: read data encodes the offset
  assign dev_rdata = 16'hD000 | {13'd0, dev_off};

  cfg_window_gate i_cfg_window_gate (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_off(acc_off),
    .acc_word(acc_word), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .resp_valid(resp_valid), .resp_data(resp_data), .cfg_open(cfg_open),
    .dev_valid(dev_valid), .dev_off(dev_off), .dev_word(dev_word),
    .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: a read accepted at an edge is answered right after it
  always @(posedge clk) begin
    mon_exp = acc_valid && !acc_wr && !rst;
    #1;
    if (!rst) begin
      chk(resp_valid == mon_exp, "R11 resp_valid", {31'd0, resp_valid}, {31'd0, mon_exp});
      if (resp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", {16'd0, resp_data}, 32'd0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(resp_data == e, "R4/R5 resp_data", {16'd0, resp_data}, {16'd0, e});
        end
      end
    end
  end

  // fwd: expect forwarding on dev_* (1) or local consumption (0)
  task automatic acc(input logic [2:0] off, input bit word, input bit wr,
                     input logic [15:0] d, input bit fwd, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_off = off; acc_word = word; acc_wr = wr; acc_wdata = d;
    if (!wr) exp_q.push_back(d);
    #1;
    chk(dev_valid == fwd, req, {31'd0, dev_valid}, {31'd0, fwd});
    if (fwd) chk(dev_off == off && dev_word == word && dev_wr == wr && dev_wdata == acc_wdata,
                 "R4 forwarded fields", {dev_wdata, 13'd0, dev_off}, {acc_wdata, 13'd0, off});
  endtask

  task automatic quiet();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] key);
    acc(3'd1, 1'b1, 1'b0, 16'hD001, 1'b1, "R4 unlock read fwd");
    acc(3'd1, 1'b1, 1'b0, 16'hD001, 1'b1, "R4 unlock read fwd");
    acc(3'd2, 1'b0, 1'b1, {8'h00, key}, 1'b1, "R4 key write fwd");
    quiet();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_open == 1'b0, "R1 closed after reset", {31'd0, cfg_open}, 32'd0);
    chk(resp_valid == 1'b0, "R1 no response in reset", {31'd0, resp_valid}, 32'd0);
    rst = 1'b0;

    // R4: closed window forwards everything
    acc(3'd0, 1'b1, 1'b0, 16'hD000, 1'b1, "R4 word read fwd");
    acc(3'd5, 1'b0, 1'b1, 16'h00AB, 1'b1, "R4 byte write fwd");
    acc(3'd3, 1'b0, 1'b0, 16'hD003, 1'b1, "R4 byte read fwd");
    quiet();

    // R3: broken sequences
    acc(3'd1, 1'b1, 1'b0, 16'hD001, 1'b1, "R3 fwd");
    acc(3'd1, 1'b0, 1'b0, 16'hD001, 1'b1, "R3 fwd");
    acc(3'd1, 1'b1, 1'b0, 16'hD001, 1'b1, "R3 fwd");
    acc(3'd2, 1'b0, 1'b1, 16'h0003, 1'b1, "R3 fwd");
    quiet();
    chk(cfg_open == 1'b0, "R3 byte read breaks", {31'd0, cfg_open}, 32'd0);
    unlock(8'h04);
    chk(cfg_open == 1'b0, "R3 wrong key", {31'd0, cfg_open}, 32'd0);
    acc(3'd1, 1'b1, 1'b0, 16'hD001, 1'b1, "R3 fwd");
    acc(3'd0, 1'b1, 1'b0, 16'hD000, 1'b1, "R3 fwd");
    acc(3'd1, 1'b1, 1'b0, 16'hD001, 1'b1, "R3 fwd");
    acc(3'd2, 1'b0, 1'b1, 16'h0003, 1'b1, "R3 fwd");
    quiet();
    chk(cfg_open == 1'b0, "R3 wrong offset breaks", {31'd0, cfg_open}, 32'd0);

    // R2: correct sequence opens
    unlock(8'h03);
    chk(cfg_open == 1'b1, "R2 window opens", {31'd0, cfg_open}, 32'd1);

    // R1/R8: reset values, control read/write
    acc(3'd3, 1'b0, 1'b0, 16'h0000, 1'b0, "R1 ctrl reset local");
    acc(3'd6, 1'b0, 1'b0, 16'h0000, 1'b0, "R1 misc reset local");
    acc(3'd3, 1'b0, 1'b1, 16'h0085, 1'b0, "R8 ctrl write local");
    acc(3'd3, 1'b0, 1'b0, 16'h0085, 1'b0, "R8 ctrl readback");

    // R5: timing bytes, word access still forwarded
    acc(3'd0, 1'b0, 1'b1, 16'h0021, 1'b0, "R5 tmg0 write");
    acc(3'd1, 1'b0, 1'b1, 16'h0032, 1'b0, "R5 tmg1 write");
    acc(3'd0, 1'b0, 1'b0, 16'h0021, 1'b0, "R5 tmg0 read");
    acc(3'd1, 1'b0, 1'b0, 16'h0032, 1'b0, "R5 tmg1 read");
    acc(3'd0, 1'b1, 1'b0, 16'hD000, 1'b1, "R5 word fwd when open");

    // R7 strap, R11 empty indices
    acc(3'd5, 1'b0, 1'b1, 16'h007F, 1'b0, "R7 strap write local");
    acc(3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, "R7 strap read");
    acc(3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, "R11 idx2 read");
    acc(3'd4, 1'b0, 1'b0, 16'h0000, 1'b0, "R11 idx4 read");
    acc(3'd7, 1'b0, 1'b0, 16'h0000, 1'b0, "R11 idx7 read");

    // R9: misc bit 0 ignored before bank enable
    acc(3'd6, 1'b0, 1'b1, 16'h0001, 1'b0, "R9 misc write");
    acc(3'd0, 1'b0, 1'b0, 16'h0021, 1'b0, "R9 still bank A");

    // R6: close
    acc(3'd2, 1'b0, 1'b1, 16'h0083, 1'b0, "R6 close not fwd");
    quiet();
    chk(cfg_open == 1'b0, "R6 window closed", {31'd0, cfg_open}, 32'd0);
    acc(3'd0, 1'b0, 1'b0, 16'hD000, 1'b1, "R6 byte read fwd after close");

    // R9: enable bank B while closed
    acc(3'd3, 1'b0, 1'b1, 16'h00C0, 1'b1, "R9 bank key fwd");
    quiet();
    unlock(8'h03);
    chk(cfg_open == 1'b1, "R2 reopen", {31'd0, cfg_open}, 32'd1);

    // R10: misc still 1 -> bank B
    acc(3'd6, 1'b0, 1'b0, 16'h0001, 1'b0, "R6 misc kept");
    acc(3'd3, 1'b0, 1'b0, 16'h0085, 1'b0, "R6 ctrl kept");
    acc(3'd0, 1'b0, 1'b1, 16'h0055, 1'b0, "R10 B0 write");
    acc(3'd1, 1'b0, 1'b1, 16'h0066, 1'b0, "R10 B1 write");
    acc(3'd0, 1'b0, 1'b0, 16'h0055, 1'b0, "R10 B0 read");
    acc(3'd1, 1'b0, 1'b0, 16'h0066, 1'b0, "R10 B1 read");
    acc(3'd6, 1'b0, 1'b1, 16'h0000, 1'b0, "R10 select A");
    acc(3'd0, 1'b0, 1'b0, 16'h0021, 1'b0, "R10 A0 intact");
    acc(3'd1, 1'b0, 1'b0, 16'h0032, 1'b0, "R10 A1 intact");
    quiet();
    quiet();
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule